// File: doc/BRIEF.md
# Linked-list DMA transfer engine

This block moves data for one DMA channel, one element per grant. When the channel arbiter pulses `start`, the engine takes a snapshot of the channel's source address, destination address, control word, link pointer and configuration word. It reads the source in units of the source width until it has gathered one element. It then writes that element out in units of the destination width and steps each address when the control word asks for it. Finally it lowers the 12-bit transfer count by one. It returns the updated register values to the register file together with a one-cycle `done` pulse. An element is `max(source width, destination width)` bytes long.

When the count runs out there are two cases. If the link pointer is nonzero, the engine reads a four-word descriptor from memory and loads it into the channel registers. If the link pointer is zero, the engine clears the channel enable. In both cases it raises `tc_pulse` alongside `done` when the exhausted control word requests a terminal-count interrupt. Memory is reached through a word-wide request/acknowledge port. Data is right-aligned on that port, and `mem_size` carries log2 of the byte count.

The controller has eight states:

| State | Action | Leaves on | Goes to |
|-------|--------|-----------|---------|
| ST_IDLE | waits for a grant | `start` | ST_READ; or, if the count is zero, ST_FETCH0 (link nonzero) or ST_DONE (link zero) |
| ST_READ | one source read per acknowledge | acknowledge of the last read | ST_WRITE |
| ST_WRITE | one destination write per acknowledge | acknowledge of the last write | ST_FETCH0 if the count runs out with a nonzero link, otherwise ST_DONE |
| ST_FETCH0 | reads the descriptor word that becomes the source address | acknowledge | ST_FETCH1 |
| ST_FETCH1 | reads the word that becomes the destination address | acknowledge | ST_FETCH2 |
| ST_FETCH2 | reads the word that becomes the control word | acknowledge | ST_FETCH3 |
| ST_FETCH3 | reads the word that becomes the link pointer | acknowledge | ST_DONE |
| ST_DONE | pulses `done` (and `tc_pulse` when due) | always | ST_IDLE |

Top module: `lldma_engine`

## Requirements
- R1: After reset `mem_req`, `done` and `tc_pulse` are low and the engine is idle.
- R2: Control bits [20:18] hold the source width code and bits [23:21] the destination width code, each log2 of the byte count. Codes above 2 are treated as 4 bytes, and `mem_size` never shows more than 2.
- R3: Source reads of the source width repeat until max(source, destination) bytes are gathered. The source address advances by the source width per read when control bit 26 is set.
- R4: Writes of the destination width cover the gathered bytes, lowest byte first, in the order they were read. The destination address advances by the destination width per write when control bit 27 is set.
- R5: With control bits 26 and 27 clear, every read and every write of the element uses the unchanged addresses.
- R6: After each element, control bits [11:0] drop by one and bits [31:12] are kept. `done` pulses for exactly one cycle, and the updated registers are valid while it is high.
- R7: When the count reaches zero with a nonzero link, four word reads at link, link+4, link+8 and link+12 load source, destination, control and link in that order. The configuration word is unchanged.
- R8: When the count reaches zero with a zero link, configuration bit 0 is cleared and the other configuration bits are kept. The engine never sets configuration bit 0 itself.
- R9: `tc_pulse` is high with `done` only when the exhausted control word has bit 31 set. It stays low on elements that do not exhaust the count.
- R10: A grant that arrives with a zero count makes no memory access and is handled at once as an exhausted count, as in R7, R8 and R9.
- R11: A request holds `mem_req`, `mem_we`, `mem_addr`, `mem_size` and `mem_wdata` steady until `mem_ack`, and each access completes exactly once.
- R12: `start` is ignored while the engine is busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| start | input | 1 | grant pulse from the arbiter |
| src_in | input | ADDR_W | channel source address |
| dst_in | input | ADDR_W | channel destination address |
| ctrl_in | input | DATA_W | channel control word |
| link_in | input | ADDR_W | channel link pointer |
| cfg_in | input | DATA_W | channel configuration word |
| mem_req | output | 1 | memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | byte address |
| mem_size | output | 2 | log2 of the access byte count |
| mem_wdata | output | DATA_W | right-aligned write data |
| mem_ack | input | 1 | access completion |
| mem_rdata | input | DATA_W | right-aligned read data, valid with mem_ack |
| done | output | 1 | element or descriptor fetch finished |
| tc_pulse | output | 1 | terminal-count event |
| src_out | output | ADDR_W | updated source address |
| dst_out | output | ADDR_W | updated destination address |
| ctrl_out | output | DATA_W | updated control word |
| link_out | output | ADDR_W | updated link pointer |
| cfg_out | output | DATA_W | updated configuration word |

## Verification
The transfer path is tried with several width pairs, and each pair tells a different part of the datapath apart:
- Byte to byte exercises plain stepping.
- Byte to word shows that the gather loop and the lane order are right.
- Word to halfword shows the scatter loop.
- Out-of-range width codes confirm the clamp to a word.

Runs with address increment off show that addresses hold, and a count of two separates a mid-list element from the final one. Chains with and without a link show descriptor loading apart from channel disable, and grants with and without bit 31 show terminal-count gating. A zero count at grant and a stray grant during a transfer probe the entry corners. The bench counts memory handshakes per grant.

// File: rtl/lldma_pkg.sv
package lldma_pkg;

    // Control word fields
    localparam int CNT_W     = 12;
    localparam int SW_LSB    = 18;
    localparam int DW_LSB    = 21;
    localparam int SINC_BIT  = 26;
    localparam int DINC_BIT  = 27;
    localparam int TCREQ_BIT = 31;

    // Configuration word fields
    localparam int CFG_EN_BIT = 0;

    // Number of words in a linked descriptor
    localparam int DESC_WORDS = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_FETCH0,
        ST_FETCH1,
        ST_FETCH2,
        ST_FETCH3,
        ST_DONE
    } lldma_state_t;

endpackage

// File: rtl/lldma_width_dec.sv
module lldma_width_dec #(
    parameter int BYTES = 4,
    parameter int OFF_W = 4
) (
    input  logic [2:0]       s_raw,
    input  logic [2:0]       d_raw,
    output logic [1:0]       s_code,
    output logic [1:0]       d_code,
    output logic [OFF_W-1:0] s_bytes,
    output logic [OFF_W-1:0] d_bytes,
    output logic [OFF_W-1:0] x_bytes
);
    localparam int MAX_CODE = $clog2(BYTES);

    always_comb begin
        // Codes wider than the data port are clamped to a full word
        s_code  = (s_raw > 3'(MAX_CODE)) ? 2'(MAX_CODE) : s_raw[1:0];
        d_code  = (d_raw > 3'(MAX_CODE)) ? 2'(MAX_CODE) : d_raw[1:0];
        s_bytes = OFF_W'(1) << s_code;
        d_bytes = OFF_W'(1) << d_code;
        x_bytes = (s_bytes > d_bytes) ? s_bytes : d_bytes;
    end

endmodule

// File: rtl/lldma_gather_buf.sv
module lldma_gather_buf #(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [OFF_W-1:0]  wr_bytes,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_off,
    input  logic [OFF_W-1:0]  rd_bytes,
    output logic [DATA_W-1:0] rd_data
);
    localparam int BYTES = DATA_W / 8;

    logic [DATA_W-1:0] wr_shift;
    logic [DATA_W-1:0] store;
    logic [DATA_W-1:0] rd_shift;

    assign wr_shift = wr_data << {wr_off, 3'b000};
    assign rd_shift = store >> {rd_off, 3'b000};

    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        logic [7:0] lane_q;
        logic       lane_hit;

        assign lane_hit = wr_en
                       && (OFF_W'(i) >= wr_off)
                       && (OFF_W'(i) < (wr_off + wr_bytes));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (lane_hit) begin
                lane_q <= wr_shift[8*i +: 8];
            end
        end

        assign store[8*i +: 8]   = lane_q;
        assign rd_data[8*i +: 8] = (OFF_W'(i) < rd_bytes) ? rd_shift[8*i +: 8] : 8'h00;
    end

endmodule

// File: rtl/lldma_engine.sv
module lldma_engine
    import lldma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] src_in,
    input  logic [ADDR_W-1:0] dst_in,
    input  logic [DATA_W-1:0] ctrl_in,
    input  logic [ADDR_W-1:0] link_in,
    input  logic [DATA_W-1:0] cfg_in,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              tc_pulse,
    output logic [ADDR_W-1:0] src_out,
    output logic [ADDR_W-1:0] dst_out,
    output logic [DATA_W-1:0] ctrl_out,
    output logic [ADDR_W-1:0] link_out,
    output logic [DATA_W-1:0] cfg_out
);
    localparam int BYTES     = DATA_W / 8;
    localparam int OFF_W     = $clog2(BYTES) + 2;
    localparam int FULL_CODE = $clog2(BYTES);

    lldma_state_t state_q, state_d;

    logic [ADDR_W-1:0] src_q, dst_q, link_q;
    logic [DATA_W-1:0] ctrl_q, cfg_q;
    logic [OFF_W-1:0]  goff_q, woff_q;
    logic              tc_q;

    logic [1:0]        s_code, d_code;
    logic [OFF_W-1:0]  s_bytes, d_bytes, x_bytes;
    logic [DATA_W-1:0] buf_rd;
    logic              last_rd, last_wr;
    logic [CNT_W-1:0]  cnt_q;
    logic              cnt_last;
    logic              in_zero;
    logic [DATA_W-1:0] en_mask;

    // ---------------- width decode and gather buffer ----------------
    lldma_width_dec #(
        .BYTES (BYTES),
        .OFF_W (OFF_W)
    ) u_wdec (
        .s_raw   (ctrl_q[SW_LSB +: 3]),
        .d_raw   (ctrl_q[DW_LSB +: 3]),
        .s_code  (s_code),
        .d_code  (d_code),
        .s_bytes (s_bytes),
        .d_bytes (d_bytes),
        .x_bytes (x_bytes)
    );

    lldma_gather_buf #(
        .DATA_W (DATA_W),
        .OFF_W  (OFF_W)
    ) u_gbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    ((state_q == ST_READ) && mem_ack),
        .wr_off   (goff_q),
        .wr_bytes (s_bytes),
        .wr_data  (mem_rdata),
        .rd_off   (woff_q),
        .rd_bytes (d_bytes),
        .rd_data  (buf_rd)
    );

    assign cnt_q    = ctrl_q[CNT_W-1:0];
    assign cnt_last = (cnt_q == CNT_W'(1));
    assign in_zero  = (ctrl_in[CNT_W-1:0] == '0);
    assign last_rd  = (goff_q + s_bytes) >= x_bytes;
    assign last_wr  = (woff_q + d_bytes) >= x_bytes;
    assign en_mask  = ~(DATA_W'(1) << CFG_EN_BIT);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (!in_zero) begin
                        state_d = ST_READ;
                    end else if (link_in != '0) begin
                        state_d = ST_FETCH0;
                    end else begin
                        state_d = ST_DONE;
                    end
                end
            end
            ST_READ: begin
                if (mem_ack && last_rd) begin
                    state_d = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (mem_ack && last_wr) begin
                    state_d = (cnt_last && (link_q != '0)) ? ST_FETCH0 : ST_DONE;
                end
            end
            ST_FETCH0: if (mem_ack) state_d = ST_FETCH1;
            ST_FETCH1: if (mem_ack) state_d = ST_FETCH2;
            ST_FETCH2: if (mem_ack) state_d = ST_FETCH3;
            ST_FETCH3: if (mem_ack) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_size  = '0;
        mem_wdata = '0;
        done      = 1'b0;
        tc_pulse  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = src_q;
                mem_size = s_code;
            end
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_q;
                mem_size  = d_code;
                mem_wdata = buf_rd;
            end
            ST_FETCH0: begin
                mem_req  = 1'b1;
                mem_addr = link_q;
                mem_size = 2'(FULL_CODE);
            end
            ST_FETCH1: begin
                mem_req  = 1'b1;
                mem_addr = link_q + ADDR_W'(BYTES);
                mem_size = 2'(FULL_CODE);
            end
            ST_FETCH2: begin
                mem_req  = 1'b1;
                mem_addr = link_q + ADDR_W'(2 * BYTES);
                mem_size = 2'(FULL_CODE);
            end
            ST_FETCH3: begin
                mem_req  = 1'b1;
                mem_addr = link_q + ADDR_W'(3 * BYTES);
                mem_size = 2'(FULL_CODE);
            end
            ST_DONE: begin
                done     = 1'b1;
                tc_pulse = tc_q;
            end
        endcase
    end

    // ---------------- channel register datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            dst_q  <= '0;
            ctrl_q <= '0;
            link_q <= '0;
            cfg_q  <= '0;
            goff_q <= '0;
            woff_q <= '0;
            tc_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        src_q  <= src_in;
                        dst_q  <= dst_in;
                        ctrl_q <= ctrl_in;
                        link_q <= link_in;
                        goff_q <= '0;
                        woff_q <= '0;
                        // zero count: treated as already exhausted
                        tc_q   <= in_zero && ctrl_in[TCREQ_BIT];
                        if (in_zero && (link_in == '0)) begin
                            cfg_q <= cfg_in & en_mask;
                        end else begin
                            cfg_q <= cfg_in;
                        end
                    end
                end
                ST_READ: begin
                    if (mem_ack) begin
                        goff_q <= goff_q + s_bytes;
                        if (ctrl_q[SINC_BIT]) begin
                            src_q <= src_q + ADDR_W'(s_bytes);
                        end
                    end
                end
                ST_WRITE: begin
                    if (mem_ack) begin
                        woff_q <= woff_q + d_bytes;
                        if (ctrl_q[DINC_BIT]) begin
                            dst_q <= dst_q + ADDR_W'(d_bytes);
                        end
                        if (last_wr) begin
                            ctrl_q <= {ctrl_q[DATA_W-1:CNT_W], cnt_q - CNT_W'(1)};
                            tc_q   <= cnt_last && ctrl_q[TCREQ_BIT];
                            if (cnt_last && (link_q == '0)) begin
                                cfg_q <= cfg_q & en_mask;
                            end
                        end
                    end
                end
                ST_FETCH0: if (mem_ack) src_q  <= ADDR_W'(mem_rdata);
                ST_FETCH1: if (mem_ack) dst_q  <= ADDR_W'(mem_rdata);
                ST_FETCH2: if (mem_ack) ctrl_q <= mem_rdata;
                ST_FETCH3: if (mem_ack) link_q <= ADDR_W'(mem_rdata);
                ST_DONE: begin
                end
            endcase
        end
    end

    assign src_out  = src_q;
    assign dst_out  = dst_q;
    assign ctrl_out = ctrl_q;
    assign link_out = link_q;
    assign cfg_out  = cfg_q;

endmodule

// File: rtl/lldma_engine_chk.sv
module lldma_engine_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [1:0]        mem_size,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic              done,
    input logic              tc_pulse,
    input logic [DATA_W-1:0] cfg_out
);
    localparam int FULL_CODE = $clog2(DATA_W / 8);

    p_hold_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                   && $stable(mem_size) && $stable(mem_wdata)));

    p_size_clamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_size <= 2'(FULL_CODE)));

    p_tc_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> done);

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    p_en_no_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_out[0]) |-> $past(start));

endmodule

bind lldma_engine lldma_engine_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_size  (mem_size),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .done      (done),
    .tc_pulse  (tc_pulse),
    .cfg_out   (cfg_out)
);

// File: tb/sim_lldma_engine.sv
`timescale 1ns/1ps
module sim_lldma_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] src_in = '0, dst_in = '0, ctrl_in = '0, link_in = '0, cfg_in = '0;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;
    logic        done, tc_pulse;
    logic [31:0] src_out, dst_out, ctrl_out, link_out, cfg_out;

    int checks = 0;
    int failures = 0;
    int acc_cnt = 0;
    logic [7:0] mem [0:511];

    logic [31:0] o_src, o_dst, o_ctrl, o_link, o_cfg;
    logic        o_tc;
    int          o_acc;

    always #5 clk = ~clk;

    lldma_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_in(src_in), .dst_in(dst_in), .ctrl_in(ctrl_in),
        .link_in(link_in), .cfg_in(cfg_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .tc_pulse(tc_pulse),
        .src_out(src_out), .dst_out(dst_out), .ctrl_out(ctrl_out),
        .link_out(link_out), .cfg_out(cfg_out)
    );

    // Memory model: answers one cycle after a request is seen
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                for (int k = 0; k < (1 << mem_size); k++)
                    mem[(mem_addr + k) & 511] = mem_wdata[8*k +: 8];
            end else begin
                logic [31:0] r;
                r = '0;
                for (int k = 0; k < (1 << mem_size); k++)
                    r[8*k +: 8] = mem[(mem_addr + k) & 511];
                mem_rdata <= r;
            end
        end else begin
            mem_ack <= 1'b0;
        end
        if (mem_req && mem_ack) acc_cnt = acc_cnt + 1;
    end

    function automatic logic [7:0] ib(input int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    function automatic logic [31:0] src_word(input int a);
        return {ib(a + 3), ib(a + 2), ib(a + 1), ib(a)};
    endfunction

    function automatic logic [31:0] rd32(input int a);
        return {mem[a + 3], mem[a + 2], mem[a + 1], mem[a]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_grant(input logic [31:0] s, d, c, l, f, input bit poke);
        @(negedge clk);
        src_in = s; dst_in = d; ctrl_in = c; link_in = l; cfg_in = f;
        acc_cnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (2) @(negedge clk);
            src_in = 32'h0; dst_in = 32'h1F0; ctrl_in = 32'h0C000004;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        o_src = src_out; o_dst = dst_out; o_ctrl = ctrl_out;
        o_link = link_out; o_cfg = cfg_out; o_tc = tc_pulse; o_acc = acc_cnt;
        @(negedge clk);
        chk("R6 done one cycle", {31'b0, done}, 32'h0);
    endtask

    task automatic t_reset;
        chk("R1 mem_req", {31'b0, mem_req}, 32'h0);
        chk("R1 done", {31'b0, done}, 32'h0);
        chk("R1 tc_pulse", {31'b0, tc_pulse}, 32'h0);
    endtask

    task automatic t_byte_copy;
        run_grant(32'h10, 32'h100, 32'h8C000002, 32'h0, 32'h8001, 1'b0);
        chk("R3 byte src step", o_src, 32'h11);
        chk("R4 byte dst step", o_dst, 32'h101);
        chk("R4 byte data", {24'b0, mem[32'h100]}, {24'b0, ib(32'h10)});
        chk("R6 count dec upper kept", o_ctrl, 32'h8C000001);
        chk("R9 no tc mid list", {31'b0, o_tc}, 32'h0);
        chk("R8 cfg kept mid list", o_cfg, 32'h8001);
        chk("R11 two accesses", o_acc, 32'd2);
        run_grant(o_src, o_dst, o_ctrl, o_link, o_cfg, 1'b0);
        chk("R4 second byte", {24'b0, mem[32'h101]}, {24'b0, ib(32'h11)});
        chk("R6 count zero", o_ctrl, 32'h8C000000);
        chk("R8 enable cleared", o_cfg, 32'h8000);
        chk("R9 tc on last", {31'b0, o_tc}, 32'h1);
    endtask

    task automatic t_gather;
        run_grant(32'h20, 32'h110, 32'h0C400001, 32'h0, 32'h1, 1'b0);
        chk("R3 gather word", rd32(32'h110), src_word(32'h20));
        chk("R3 gather src", o_src, 32'h24);
        chk("R4 gather dst", o_dst, 32'h114);
        chk("R11 gather accesses", o_acc, 32'd5);
        chk("R9 tc suppressed", {31'b0, o_tc}, 32'h0);
        chk("R8 gather disable", o_cfg, 32'h0);
    endtask

    task automatic t_scatter;
        run_grant(32'h30, 32'h120, 32'h0C280001, 32'h0, 32'h1, 1'b0);
        chk("R4 scatter word", rd32(32'h120), src_word(32'h30));
        chk("R3 scatter src", o_src, 32'h34);
        chk("R4 scatter dst", o_dst, 32'h124);
        chk("R11 scatter accesses", o_acc, 32'd3);
    endtask

    task automatic t_no_inc;
        run_grant(32'h40, 32'h130, 32'h00240002, 32'h0, 32'h1, 1'b0);
        chk("R5 src held", o_src, 32'h40);
        chk("R5 dst held", o_dst, 32'h130);
        chk("R5 half written", {16'b0, mem[32'h131], mem[32'h130]}, {16'b0, ib(32'h41), ib(32'h40)});
        chk("R5 next byte untouched", {24'b0, mem[32'h132]}, 32'h0);
        chk("R6 count one left", o_ctrl, 32'h00240001);
    endtask

    task automatic t_link;
        run_grant(32'h48, 32'h138, 32'h0C000001, 32'h180, 32'h1, 1'b0);
        chk("R7 src loaded", o_src, 32'h50);
        chk("R7 dst loaded", o_dst, 32'h140);
        chk("R7 ctrl loaded", o_ctrl, 32'h8C000001);
        chk("R7 link loaded", o_link, 32'h0);
        chk("R7 cfg unchanged", o_cfg, 32'h1);
        chk("R7 six accesses", o_acc, 32'd6);
        chk("R9 old ctrl no tc", {31'b0, o_tc}, 32'h0);
        chk("R7 element before fetch", {24'b0, mem[32'h138]}, {24'b0, ib(32'h48)});
        run_grant(o_src, o_dst, o_ctrl, o_link, o_cfg, 1'b0);
        chk("R7 chained element", {24'b0, mem[32'h140]}, {24'b0, ib(32'h50)});
        chk("R9 chained tc", {31'b0, o_tc}, 32'h1);
        chk("R8 chained disable", o_cfg, 32'h0);
    endtask

    task automatic t_zero_count;
        run_grant(32'h5A, 32'h15A, 32'h80000000, 32'h0, 32'h3, 1'b0);
        chk("R10 no access", o_acc, 32'd0);
        chk("R10 disable", o_cfg, 32'h2);
        chk("R10 tc", {31'b0, o_tc}, 32'h1);
        chk("R10 src kept", o_src, 32'h5A);
    endtask

    task automatic t_clamp;
        run_grant(32'h60, 32'h150, 32'h0CF40001, 32'h0, 32'h1, 1'b0);
        chk("R2 clamp word", rd32(32'h150), src_word(32'h60));
        chk("R2 clamp src", o_src, 32'h64);
        chk("R2 clamp dst", o_dst, 32'h154);
        chk("R2 clamp accesses", o_acc, 32'd2);
    endtask

    task automatic t_busy_start;
        run_grant(32'h70, 32'h160, 32'h0C400001, 32'h0, 32'h1, 1'b1);
        chk("R12 src unaffected", o_src, 32'h74);
        chk("R12 dst unaffected", o_dst, 32'h164);
        chk("R12 data", rd32(32'h160), src_word(32'h70));
        chk("R12 stray dest clean", {24'b0, mem[32'h1F0]}, 32'h0);
        chk("R12 accesses", o_acc, 32'd5);
        repeat (4) @(negedge clk);
        chk("R12 stays idle", {31'b0, mem_req}, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int a = 0; a < 512; a++) mem[a] = (a < 256) ? ib(a) : 8'h00;
        {mem[32'h183], mem[32'h182], mem[32'h181], mem[32'h180]} = 32'h00000050;
        {mem[32'h187], mem[32'h186], mem[32'h185], mem[32'h184]} = 32'h00000140;
        {mem[32'h18B], mem[32'h18A], mem[32'h189], mem[32'h188]} = 32'h8C000001;
        {mem[32'h18F], mem[32'h18E], mem[32'h18D], mem[32'h18C]} = 32'h00000000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte_copy();
        t_gather();
        t_scatter();
        t_no_inc();
        t_link();
        t_zero_count();
        t_clamp();
        t_busy_start();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule